// File: doc/BRIEF.md
# Dual-Section Latched Bidirectional Bus Transceiver

This block passes 8-bit words between an A side and a B side in two independent sections. Each section holds two storage words, one for each direction. An A-side word can therefore be parked for the B side while a B-side word is parked for the A side. Each direction of each section is steered by three active-low controls:

- a direction enable;
- a capture control, which opens the storage when low;
- an output enable.

Every port is split into an input vector, an output vector and a per-bit drive-enable vector, so that a chip-level pad ring can build the tri-state pins. An undriven output vector reads as zero.

Storage is clocked. A direction is "open" in a cycle when its direction enable and its capture control are both low. While it is open, the shown word follows the source input in the same cycle, and the storage register takes the source at each rising clock edge. When the direction closes, because either control rises, the word sampled at the last open clock edge is kept and shown. Source data must therefore be present at a clock edge while the direction is open for it to be stored. Reset clears both storage words of every section to zero.

The output drive of a direction depends only on that direction's own direction enable and output enable. The data paths carry no valid/ready handshake: each control pin has a level meaning that takes effect in the cycle it is applied, and the block never pushes back.

Top module: `dual_latch_xcvr`

## Requirements
- R1: With a direction's enable low and its capture control low, the word shown by that direction equals its source input in the same cycle and follows every change of it.
- R2: With the direction enable low, raising the capture control keeps the word that was on the source at the last clock edge while open. The word then stays unchanged, whatever the source does, for as long as the capture control stays high.
- R3: With the capture control low, raising the direction enable also keeps the word sampled at the last open clock edge. The word is shown again unchanged once the direction enable returns low with the capture control high.
- R4: A destination side is driven only when its direction enable and its output enable are both low. In that case all 8 drive-enable bits of that side are 1 and the output equals the shown word, not inverted.
- R5: When either the direction enable or the output enable is high, all 8 drive-enable bits of the destination side are 0 and its output is 0. A word captured while the output enable is high is shown once the output enable goes low.
- R6: The B-to-A direction behaves like the A-to-B direction with its own three controls. The A-side drive-enable and output depend only on the B-to-A controls, and the B side depends only on the A-to-B controls.
- R7: Section 0 uses bits 7:0 of every data vector and bit 0 of every control vector; section 1 uses bits 15:8 and bit 1. Activity in one section never changes the other section's outputs.
- R8: After reset, both storage words of every section read zero.
- R9: One section holds an A-to-B word and a B-to-A word at the same time, and both can be driven in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage samples on its rising edge |
| rst_n | input | 1 | Active-low reset, clears all storage words |
| a_in | input | 16 | A-side data in, section s at bits 8s+7:8s |
| a_out | output | 16 | A-side data out (zero when not driven) |
| a_oe | output | 16 | A-side per-bit drive enable, 1 = driven |
| b_in | input | 16 | B-side data in |
| b_out | output | 16 | B-side data out (zero when not driven) |
| b_oe | output | 16 | B-side per-bit drive enable, 1 = driven |
| ab_en_n | input | 2 | A-to-B direction enable per section, active low |
| ab_le_n | input | 2 | A-to-B capture control per section, low = open |
| ab_oe_n | input | 2 | A-to-B output enable per section, active low |
| ba_en_n | input | 2 | B-to-A direction enable per section, active low |
| ba_le_n | input | 2 | B-to-A capture control per section, low = open |
| ba_oe_n | input | 2 | B-to-A output enable per section, active low |

## Verification
The bench changes the source word in the very cycle a control rises. A design that samples the closing cycle, instead of the last open edge, would show the new word rather than the held one. It closes a direction by its enable as well as by its capture control, since a design storing only on the capture control would lose the word when the enable rises. It loads a word with the output enable high and later shows it, catching a design that blocks capture when undriven. It also runs both directions and both sections at once, which exposes crossed enables or a shared storage word through a wrong value on the other side.

// File: rtl/dlx_pkg.sv
package dlx_pkg;

  // Three active-low controls steering one direction of one section.
  typedef struct packed {
    logic en_n;  // direction enable
    logic le_n;  // capture control, low = open
    logic oe_n;  // output enable
  } dlx_ctrl_t;

endpackage

// File: rtl/dlx_store.sv
module dlx_store #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dlx_pkg::dlx_ctrl_t  ctl,
  input  logic [DATA_W-1:0]   src,
  output logic [DATA_W-1:0]   shown
);

  logic              open_w;
  logic [DATA_W-1:0] held_q;

  assign open_w = ~ctl.en_n & ~ctl.le_n;

  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= '0;
    else if (open_w) held_q <= src;
  end

  assign shown = open_w ? src : held_q;

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(open_w) |-> $stable(held_q));  // R2
  AST_CAPTURE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(open_w) |-> held_q == $past(src));  // R1
  AST_SHOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.en_n |-> shown == held_q);  // R3

endmodule

// File: rtl/dlx_drive.sv
module dlx_drive #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dlx_pkg::dlx_ctrl_t  ctl,
  input  logic [DATA_W-1:0]   shown,
  output logic [DATA_W-1:0]   out,
  output logic [DATA_W-1:0]   oe
);

  logic drive_w;

  assign drive_w = ~ctl.en_n & ~ctl.oe_n;
  assign oe      = {DATA_W{drive_w}};
  assign out     = drive_w ? shown : '0;

  AST_OE_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    oe == '0 || oe == '1);  // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    oe == '0 |-> out == '0);  // R5
  AST_DRIVE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    oe == '1 |-> out == shown);  // R4

endmodule

// File: rtl/dlx_section.sv
module dlx_section #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dlx_pkg::dlx_ctrl_t  ab_ctl,
  input  dlx_pkg::dlx_ctrl_t  ba_ctl,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   b_in,
  output logic [DATA_W-1:0]   a_out,
  output logic [DATA_W-1:0]   a_oe,
  output logic [DATA_W-1:0]   b_out,
  output logic [DATA_W-1:0]   b_oe
);

  logic [DATA_W-1:0] ab_shown;
  logic [DATA_W-1:0] ba_shown;

  // A-to-B: stored from A, driven onto B
  dlx_store #(.DATA_W(DATA_W)) u_ab_store (
    .clk(clk), .rst_n(rst_n), .ctl(ab_ctl), .src(a_in), .shown(ab_shown));
  dlx_drive #(.DATA_W(DATA_W)) u_ab_drive (
    .clk(clk), .rst_n(rst_n), .ctl(ab_ctl), .shown(ab_shown),
    .out(b_out), .oe(b_oe));

  // B-to-A: stored from B, driven onto A
  dlx_store #(.DATA_W(DATA_W)) u_ba_store (
    .clk(clk), .rst_n(rst_n), .ctl(ba_ctl), .src(b_in), .shown(ba_shown));
  dlx_drive #(.DATA_W(DATA_W)) u_ba_drive (
    .clk(clk), .rst_n(rst_n), .ctl(ba_ctl), .shown(ba_shown),
    .out(a_out), .oe(a_oe));

  AST_A_SIDE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_ctl.en_n || ba_ctl.oe_n) |-> a_oe == '0);  // R6
  AST_B_SIDE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_ctl.en_n || ab_ctl.oe_n) |-> b_oe == '0);  // R6

endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr #(
  parameter int DATA_W   = 8,
  parameter int NUM_SECT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SECT*DATA_W-1:0]    a_in,
  output logic [NUM_SECT*DATA_W-1:0]    a_out,
  output logic [NUM_SECT*DATA_W-1:0]    a_oe,
  input  logic [NUM_SECT*DATA_W-1:0]    b_in,
  output logic [NUM_SECT*DATA_W-1:0]    b_out,
  output logic [NUM_SECT*DATA_W-1:0]    b_oe,
  input  logic [NUM_SECT-1:0]           ab_en_n,
  input  logic [NUM_SECT-1:0]           ab_le_n,
  input  logic [NUM_SECT-1:0]           ab_oe_n,
  input  logic [NUM_SECT-1:0]           ba_en_n,
  input  logic [NUM_SECT-1:0]           ba_le_n,
  input  logic [NUM_SECT-1:0]           ba_oe_n
);

  localparam int TOT_W = NUM_SECT * DATA_W;

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
    dlx_pkg::dlx_ctrl_t ab_ctl;
    dlx_pkg::dlx_ctrl_t ba_ctl;

    assign ab_ctl = '{en_n: ab_en_n[g], le_n: ab_le_n[g], oe_n: ab_oe_n[g]};
    assign ba_ctl = '{en_n: ba_en_n[g], le_n: ba_le_n[g], oe_n: ba_oe_n[g]};

    dlx_section #(.DATA_W(DATA_W)) u_sect (
      .clk   (clk),
      .rst_n (rst_n),
      .ab_ctl(ab_ctl),
      .ba_ctl(ba_ctl),
      .a_in  (a_in [g*DATA_W +: DATA_W]),
      .b_in  (b_in [g*DATA_W +: DATA_W]),
      .a_out (a_out[g*DATA_W +: DATA_W]),
      .a_oe  (a_oe [g*DATA_W +: DATA_W]),
      .b_out (b_out[g*DATA_W +: DATA_W]),
      .b_oe  (b_oe [g*DATA_W +: DATA_W])
    );

    AST_SECT_DRIVE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_en_n[g] || ab_oe_n[g]) |-> b_out[g*DATA_W +: DATA_W] == '0);  // R7
  end

  AST_NO_X_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({a_oe, b_oe}) && TOT_W > 0);  // R4

endmodule

// File: tb/dual_latch_xcvr_bench.sv
module dual_latch_xcvr_bench;
  localparam int NS = 2;
  localparam int W  = 8;
  localparam int TW = NS * W;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_n;
  logic [TW-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
  logic [NS-1:0] ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;

  dual_latch_xcvr #(.DATA_W(W), .NUM_SECT(NS)) u_dual_latch_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n));

  typedef struct {
    string         tag;
    logic [TW-1:0] ao, aoe, bo, boe;
  } exp_t;

  exp_t          sbq[$];
  logic [W-1:0]  ab_mem[NS];
  logic [W-1:0]  ba_mem[NS];
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;

  // staged stimulus, applied at the next falling edge
  logic [TW-1:0] nx_a, nx_b;
  logic [NS-1:0] nx_ab_en, nx_ab_le, nx_ab_oe, nx_ba_en, nx_ba_le, nx_ba_oe;

  task automatic set_ab(input int s, input bit en, input bit le, input bit oe);
    nx_ab_en[s] = en; nx_ab_le[s] = le; nx_ab_oe[s] = oe;
  endtask

  task automatic set_ba(input int s, input bit en, input bit le, input bit oe);
    nx_ba_en[s] = en; nx_ba_le[s] = le; nx_ba_oe[s] = oe;
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic apply(input string tag);
    exp_t         e;
    logic         op_ab, op_ba, dr_ab, dr_ba;
    logic [W-1:0] v_ab, v_ba;
    @(negedge clk);
    a_in = nx_a; b_in = nx_b;
    ab_en_n = nx_ab_en; ab_le_n = nx_ab_le; ab_oe_n = nx_ab_oe;
    ba_en_n = nx_ba_en; ba_le_n = nx_ba_le; ba_oe_n = nx_ba_oe;
    e.tag = tag; e.ao = '0; e.aoe = '0; e.bo = '0; e.boe = '0;
    for (int s = 0; s < NS; s++) begin
      op_ab = !nx_ab_en[s] && !nx_ab_le[s];
      op_ba = !nx_ba_en[s] && !nx_ba_le[s];
      v_ab  = op_ab ? nx_a[s*W +: W] : ab_mem[s];
      v_ba  = op_ba ? nx_b[s*W +: W] : ba_mem[s];
      dr_ab = !nx_ab_en[s] && !nx_ab_oe[s];
      dr_ba = !nx_ba_en[s] && !nx_ba_oe[s];
      if (dr_ab) begin e.bo[s*W +: W] = v_ab; e.boe[s*W +: W] = '1; end
      if (dr_ba) begin e.ao[s*W +: W] = v_ba; e.aoe[s*W +: W] = '1; end
      if (op_ab) ab_mem[s] = nx_a[s*W +: W];
      if (op_ba) ba_mem[s] = nx_b[s*W +: W];
    end
    sbq.push_back(e);
  endtask

  // Monitor: compares the outputs late in each cycle, before the next rising edge.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        n_run++;
        if (a_out !== e.ao || a_oe !== e.aoe || b_out !== e.bo || b_oe !== e.boe) begin
          n_fail++;
          $display("FAIL %s: a_out=%h exp %h a_oe=%h exp %h b_out=%h exp %h b_oe=%h exp %h",
                   e.tag, a_out, e.ao, a_oe, e.aoe, b_out, e.bo, b_oe, e.boe);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin ab_mem[s] = '0; ba_mem[s] = '0; end
    nx_a = '0; nx_b = '0;
    nx_ab_en = '1; nx_ab_le = '1; nx_ab_oe = '1;
    nx_ba_en = '1; nx_ba_le = '1; nx_ba_oe = '1;
    a_in = '0; b_in = '0;
    ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
    ba_en_n = '1; ba_le_n = '1; ba_oe_n = '1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    apply("R5 idle after reset, nothing driven");
    for (int s = 0; s < NS; s++) begin set_ab(s, 0, 1, 0); set_ba(s, 0, 1, 0); end
    apply("R8 reset words read zero");

    set_ab(0, 0, 0, 0); nx_a[7:0] = 8'h5A;
    apply("R1 transparent A to B");
    nx_a[7:0] = 8'hC3;
    apply("R1 transparent follows source");
    set_ab(0, 0, 1, 0); nx_a[7:0] = 8'h0F;
    apply("R2 hold on capture rise");
    nx_a[7:0] = 8'hF0;
    apply("R2 hold stays while capture high");

    set_ab(0, 0, 0, 0); nx_a[7:0] = 8'h77;
    apply("R1 reopen");
    set_ab(0, 1, 0, 0); nx_a[7:0] = 8'h11;
    apply("R5 direction enable high, not driven");
    set_ab(0, 0, 1, 0);
    apply("R3 hold on direction enable rise");

    set_ab(0, 0, 0, 1); nx_a[7:0] = 8'h3C;
    apply("R5 capture while output enable high");
    set_ab(0, 0, 1, 0); nx_a[7:0] = 8'h99;
    apply("R5 word captured while undriven is shown");
    set_ab(0, 0, 1, 1);
    apply("R4 output enable high drops drive");
    set_ab(0, 0, 1, 0);
    apply("R4 output enable low drives held word");

    set_ba(0, 0, 0, 0); nx_b[7:0] = 8'hA5;
    apply("R6 B to A transparent");
    set_ba(0, 0, 1, 0); nx_b[7:0] = 8'h5B;
    apply("R6 B to A hold");
    apply("R9 both words held and driven");

    set_ab(1, 0, 0, 0); nx_a[15:8] = 8'hE1;
    set_ba(1, 0, 0, 0); nx_b[15:8] = 8'h1E;
    apply("R7 section 1 transparent both ways");
    set_ab(1, 0, 1, 0); set_ba(1, 0, 1, 0);
    nx_a[15:8] = 8'h00; nx_b[15:8] = 8'hFF;
    apply("R7 section 1 hold");
    set_ab(0, 0, 0, 0); nx_a[7:0] = 8'h42;
    apply("R7 section 0 change leaves section 1");
    set_ab(0, 1, 1, 1); set_ba(0, 1, 1, 1);
    apply("R5 section 0 fully off");

    set_ba(1, 0, 0, 0); nx_b[15:8] = 8'h6D;
    apply("R1 section 1 B to A reload");
    set_ba(1, 1, 0, 0); nx_b[15:8] = 8'h24;
    apply("R3 B to A direction enable high");
    set_ba(1, 0, 1, 0);
    apply("R3 B to A word kept after enable rise");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule